// File: doc/BRIEF.md
# Virtual-Link Ingress Admission Filter

This block decides whether each incoming frame may enter the switch. For every frame it receives the parsed header fields (destination MAC, VLAN ID and priority code point) with a one-cycle valid strobe. It compares that key against a small table of virtual-link entries. When an entry matches, the frame is admitted only if two conditions hold: the link's time-scheduled gate is open, and the link has a forwarding action. An admitted frame is given either the link's programmed destination port mask or the CPU port. Any other matched frame is dropped. Frames that match no entry pass through ungated and carry a no-match flag, so that ordinary forwarding can handle them.

The gate vector, one bit per link, comes from an external schedule engine. Table entries are loaded through a simple write port. Each link keeps two saturating counters, one for admitted frames and one for dropped frames, and both are visible on the outputs at all times.

Top module: `vl_admit`

## Requirements
- R1: A table entry matches a frame only when the entry is enabled and its destination MAC, VLAN ID and PCP all equal the frame's fields. A difference in any one field gives no match.
- R2: When several enabled entries match, the entry with the lowest index is chosen and reported on `dec_idx_o`.
- R3: `dec_valid_o` is high in exactly the cycle after a cycle with `frame_valid_i` high. Otherwise it is low.
- R4: A matched link with action code 1 (redirect) and its gate bit `gate_open_i[idx]` high is admitted (`dec_accept_o`=1, `dec_match_o`=1), and `dec_ports_o` equals the entry's configured port mask.
- R5: A matched link with action code 2 (trap) and an open gate is admitted, and `dec_ports_o` is a one-hot mask with only bit `CPU_PORT` set.
- R6: A matched link whose gate bit is low is dropped (`dec_accept_o`=0, `dec_match_o`=1, `dec_ports_o`=0).
- R7: A matched link with action code 0 or 3 (no forwarding action) is dropped whatever its gate state.
- R8: A frame that matches no entry gives `dec_accept_o`=1, `dec_match_o`=0, `dec_idx_o`=0 and `dec_ports_o`=0, and it changes no counter.
- R9: For a matched frame, the chosen link's passed counter increments by one if the frame is admitted, and its dropped counter increments by one if it is dropped. The increment lands at the same edge that registers the decision. Counter k occupies bits [k*CNT_W +: CNT_W] of `pass_cnt_o` and `drop_cnt_o`.
- R10: Each counter saturates at all ones and holds there.
- R11: After reset, `dec_valid_o` is low, all counters are zero and all table entries are disabled.
- R12: A configuration write takes effect at its clock edge. A frame strobed in the same cycle is decided with the old entry, and a later frame is decided with the new one. Writing an entry with the enable bit low removes it from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_valid_i | input | 1 | Header fields valid this cycle |
| frame_dmac_i | input | 48 | Destination MAC of the frame |
| frame_vid_i | input | 12 | VLAN ID of the frame |
| frame_pcp_i | input | 3 | Priority code point of the frame |
| gate_open_i | input | NUM_LINKS | Per-link gate state from the schedule engine |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | IDX_W | Entry index written |
| cfg_en_i | input | 1 | Entry enable |
| cfg_dmac_i | input | 48 | Entry destination MAC |
| cfg_vid_i | input | 12 | Entry VLAN ID |
| cfg_pcp_i | input | 3 | Entry PCP |
| cfg_act_i | input | 2 | Entry action: 0 none, 1 redirect, 2 trap, 3 none |
| cfg_ports_i | input | NUM_PORTS | Entry destination port mask |
| dec_valid_o | output | 1 | Decision valid |
| dec_accept_o | output | 1 | Frame admitted |
| dec_match_o | output | 1 | Frame matched a link |
| dec_idx_o | output | IDX_W | Matched link index |
| dec_ports_o | output | NUM_PORTS | Destination port mask |
| pass_cnt_o | output | NUM_LINKS*CNT_W | Per-link admitted counters |
| drop_cnt_o | output | NUM_LINKS*CNT_W | Per-link dropped counters |

## Verification
The bench keeps the default eight links and five ports, with the CPU on port 4. It lowers CNT_W to 4, so that both counters of a link reach their saturation value of 15 after a few dozen frames, not four billion. With the full table width available, two enabled entries can hold the same key, which exercises the lowest-index choice. Removing the winner then shows the higher-indexed entry taking over.

// File: rtl/vl_admit_pkg.sv
package vl_admit_pkg;
  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_REDIRECT = 2'd1,
    ACT_TRAP     = 2'd2,
    ACT_RSVD     = 2'd3
  } vl_act_e;
endpackage

// File: rtl/vl_key_table.sv
module vl_key_table #(
  parameter int NUM_LINKS = 8,
  parameter int NUM_PORTS = 5,
  parameter int MAC_W     = 48,
  parameter int VID_W     = 12,
  parameter int PCP_W     = 3,
  localparam int IDX_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_idx_i,
  input  logic                 cfg_en_i,
  input  logic [MAC_W-1:0]     cfg_dmac_i,
  input  logic [VID_W-1:0]     cfg_vid_i,
  input  logic [PCP_W-1:0]     cfg_pcp_i,
  input  logic [1:0]           cfg_act_i,
  input  logic [NUM_PORTS-1:0] cfg_ports_i,
  input  logic [MAC_W-1:0]     key_dmac_i,
  input  logic [VID_W-1:0]     key_vid_i,
  input  logic [PCP_W-1:0]     key_pcp_i,
  output logic [NUM_LINKS-1:0] hit_o,
  output logic [1:0]           act_o   [NUM_LINKS],
  output logic [NUM_PORTS-1:0] ports_o [NUM_LINKS]
);
  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_entry
    logic             en_q;
    logic [MAC_W-1:0] dmac_q;
    logic [VID_W-1:0] vid_q;
    logic [PCP_W-1:0] pcp_q;
    logic [1:0]       act_q;
    logic [NUM_PORTS-1:0] ports_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q    <= 1'b0;
        dmac_q  <= '0;
        vid_q   <= '0;
        pcp_q   <= '0;
        act_q   <= 2'd0;
        ports_q <= '0;
      end else if (cfg_we_i && cfg_idx_i == IDX_W'(k)) begin
        en_q    <= cfg_en_i;
        dmac_q  <= cfg_dmac_i;
        vid_q   <= cfg_vid_i;
        pcp_q   <= cfg_pcp_i;
        act_q   <= cfg_act_i;
        ports_q <= cfg_ports_i;
      end
    end

    assign hit_o[k]   = en_q && dmac_q == key_dmac_i && vid_q == key_vid_i && pcp_q == key_pcp_i;
    assign act_o[k]   = act_q;
    assign ports_o[k] = ports_q;
  end
endmodule

// File: rtl/vl_prio_pick.sv
module vl_prio_pick #(
  parameter int NUM_LINKS = 8,
  localparam int IDX_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic [NUM_LINKS-1:0] req_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  // walk downward so the lowest set index is left in idx_o
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_LINKS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vl_stat_counters.sv
module vl_stat_counters #(
  parameter int NUM_LINKS = 8,
  parameter int CNT_W     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LINKS-1:0]       pass_inc_i,
  input  logic [NUM_LINKS-1:0]       drop_inc_i,
  output logic [NUM_LINKS*CNT_W-1:0] pass_cnt_o,
  output logic [NUM_LINKS*CNT_W-1:0] drop_cnt_o
);
  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_link
    logic [CNT_W-1:0] pass_q, drop_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pass_q <= '0;
        drop_q <= '0;
      end else begin
        if (pass_inc_i[k] && pass_q != '1) pass_q <= pass_q + 1'b1;
        if (drop_inc_i[k] && drop_q != '1) drop_q <= drop_q + 1'b1;
      end
    end

    assign pass_cnt_o[k*CNT_W +: CNT_W] = pass_q;
    assign drop_cnt_o[k*CNT_W +: CNT_W] = drop_q;
  end
endmodule

// File: rtl/vl_admit.sv
module vl_admit
  import vl_admit_pkg::*;
#(
  parameter int NUM_LINKS = 8,
  parameter int NUM_PORTS = 5,
  parameter int CPU_PORT  = 4,
  parameter int CNT_W     = 32,
  parameter int MAC_W     = 48,
  parameter int VID_W     = 12,
  parameter int PCP_W     = 3,
  localparam int IDX_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_valid_i,
  input  logic [MAC_W-1:0]           frame_dmac_i,
  input  logic [VID_W-1:0]           frame_vid_i,
  input  logic [PCP_W-1:0]           frame_pcp_i,
  input  logic [NUM_LINKS-1:0]       gate_open_i,
  input  logic                       cfg_we_i,
  input  logic [IDX_W-1:0]           cfg_idx_i,
  input  logic                       cfg_en_i,
  input  logic [MAC_W-1:0]           cfg_dmac_i,
  input  logic [VID_W-1:0]           cfg_vid_i,
  input  logic [PCP_W-1:0]           cfg_pcp_i,
  input  logic [1:0]                 cfg_act_i,
  input  logic [NUM_PORTS-1:0]       cfg_ports_i,
  output logic                       dec_valid_o,
  output logic                       dec_accept_o,
  output logic                       dec_match_o,
  output logic [IDX_W-1:0]           dec_idx_o,
  output logic [NUM_PORTS-1:0]       dec_ports_o,
  output logic [NUM_LINKS*CNT_W-1:0] pass_cnt_o,
  output logic [NUM_LINKS*CNT_W-1:0] drop_cnt_o
);
  localparam logic [NUM_PORTS-1:0] CPU_MASK = NUM_PORTS'(1) << CPU_PORT;

  logic [NUM_LINKS-1:0] hit;
  logic [1:0]           ent_act   [NUM_LINKS];
  logic [NUM_PORTS-1:0] ent_ports [NUM_LINKS];
  logic                 found;
  logic [IDX_W-1:0]     win_idx;
  vl_act_e              win_act;
  logic                 has_fwd, admit;
  logic [NUM_PORTS-1:0] fwd_ports;
  logic [NUM_LINKS-1:0] pass_inc, drop_inc;

  vl_key_table #(
    .NUM_LINKS(NUM_LINKS), .NUM_PORTS(NUM_PORTS),
    .MAC_W(MAC_W), .VID_W(VID_W), .PCP_W(PCP_W)
  ) i_table (
    .clk_i, .rst_ni,
    .cfg_we_i, .cfg_idx_i, .cfg_en_i, .cfg_dmac_i, .cfg_vid_i,
    .cfg_pcp_i, .cfg_act_i, .cfg_ports_i,
    .key_dmac_i (frame_dmac_i),
    .key_vid_i  (frame_vid_i),
    .key_pcp_i  (frame_pcp_i),
    .hit_o      (hit),
    .act_o      (ent_act),
    .ports_o    (ent_ports)
  );

  vl_prio_pick #(.NUM_LINKS(NUM_LINKS)) i_pick (
    .req_i   (hit),
    .found_o (found),
    .idx_o   (win_idx)
  );

  always_comb begin
    win_act   = vl_act_e'(ent_act[win_idx]);
    has_fwd   = (win_act == ACT_REDIRECT) || (win_act == ACT_TRAP);
    admit     = !found || (has_fwd && gate_open_i[win_idx]);
    fwd_ports = '0;
    if (found && admit) fwd_ports = (win_act == ACT_TRAP) ? CPU_MASK : ent_ports[win_idx];
    pass_inc  = '0;
    drop_inc  = '0;
    if (frame_valid_i && found) begin
      if (admit) pass_inc[win_idx] = 1'b1;
      else       drop_inc[win_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_match_o  <= 1'b0;
      dec_idx_o    <= '0;
      dec_ports_o  <= '0;
    end else begin
      dec_valid_o <= frame_valid_i;
      if (frame_valid_i) begin
        dec_accept_o <= admit;
        dec_match_o  <= found;
        dec_idx_o    <= found ? win_idx : '0;
        dec_ports_o  <= fwd_ports;
      end
    end
  end

  vl_stat_counters #(.NUM_LINKS(NUM_LINKS), .CNT_W(CNT_W)) i_stats (
    .clk_i, .rst_ni,
    .pass_inc_i (pass_inc),
    .drop_inc_i (drop_inc),
    .pass_cnt_o,
    .drop_cnt_o
  );
endmodule

// File: rtl/vl_admit_chk.sv
module vl_admit_chk #(
  parameter int NUM_LINKS = 8,
  parameter int NUM_PORTS = 5,
  parameter int CNT_W     = 32,
  parameter int IDX_W     = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       frame_valid_i,
  input logic                       dec_valid_o,
  input logic                       dec_accept_o,
  input logic                       dec_match_o,
  input logic [IDX_W-1:0]           dec_idx_o,
  input logic [NUM_PORTS-1:0]       dec_ports_o,
  input logic [NUM_LINKS*CNT_W-1:0] pass_cnt_o,
  input logic [NUM_LINKS*CNT_W-1:0] drop_cnt_o
);
  // R3
  valid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_i |=> dec_valid_o);
  // R3
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_valid_i |=> !dec_valid_o);
  // R8
  nomatch_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !dec_match_o) |-> (dec_accept_o && dec_ports_o == '0 && dec_idx_o == '0));
  // R6
  drop_no_ports_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !dec_accept_o) |-> (dec_match_o && dec_ports_o == '0));
  // R9
  idle_counters_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> ($stable(pass_cnt_o) && $stable(drop_cnt_o)));

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_mono
    // R10
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pass_cnt_o[k*CNT_W +: CNT_W] >= $past(pass_cnt_o[k*CNT_W +: CNT_W])) &&
      (drop_cnt_o[k*CNT_W +: CNT_W] >= $past(drop_cnt_o[k*CNT_W +: CNT_W])));
  end
endmodule

bind vl_admit vl_admit_chk #(
  .NUM_LINKS(NUM_LINKS), .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) i_vl_admit_chk (
  .clk_i, .rst_ni, .frame_valid_i, .dec_valid_o, .dec_accept_o,
  .dec_match_o, .dec_idx_o, .dec_ports_o, .pass_cnt_o, .drop_cnt_o
);

// File: tb/test_vl_admit.sv
`timescale 1ns/1ps
module test_vl_admit;
  localparam int NL = 8, NP = 5, CPU = 4, CW = 4, IW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           fv = 0;
  logic [47:0]    f_dmac = '0;
  logic [11:0]    f_vid = '0;
  logic [2:0]     f_pcp = '0;
  logic [NL-1:0]  gate = '0;
  logic           we = 0, w_en = 0;
  logic [IW-1:0]  w_idx = '0;
  logic [47:0]    w_dmac = '0;
  logic [11:0]    w_vid = '0;
  logic [2:0]     w_pcp = '0;
  logic [1:0]     w_act = '0;
  logic [NP-1:0]  w_ports = '0;

  logic d_valid, d_acc, d_match;
  logic [IW-1:0] d_idx;
  logic [NP-1:0] d_ports;
  logic [NL*CW-1:0] pass_cnt, drop_cnt;

  vl_admit #(.NUM_LINKS(NL), .NUM_PORTS(NP), .CPU_PORT(CPU), .CNT_W(CW)) i_vl_admit (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .frame_dmac_i(f_dmac),
    .frame_vid_i(f_vid), .frame_pcp_i(f_pcp), .gate_open_i(gate),
    .cfg_we_i(we), .cfg_idx_i(w_idx), .cfg_en_i(w_en), .cfg_dmac_i(w_dmac),
    .cfg_vid_i(w_vid), .cfg_pcp_i(w_pcp), .cfg_act_i(w_act), .cfg_ports_i(w_ports),
    .dec_valid_o(d_valid), .dec_accept_o(d_acc), .dec_match_o(d_match),
    .dec_idx_o(d_idx), .dec_ports_o(d_ports), .pass_cnt_o(pass_cnt), .drop_cnt_o(drop_cnt)
  );

  int checks = 0, failures = 0;
  // reference model state
  bit m_en [NL];
  logic [47:0] m_dmac [NL];
  logic [11:0] m_vid [NL];
  logic [2:0]  m_pcp [NL];
  logic [1:0]  m_act [NL];
  logic [NP-1:0] m_ports [NL];
  int m_pass [NL], m_drop [NL];
  bit e_valid = 0, e_acc = 0, e_match = 0;
  int e_idx = 0;
  logic [NP-1:0] e_ports = '0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk("R3", "dec_valid", d_valid, e_valid);
    if (e_valid) begin
      chk(tag, "accept", d_acc, e_acc);
      chk(tag, "match", d_match, e_match);
      chk(tag, "idx", d_idx, e_idx);
      chk(tag, "ports", d_ports, e_ports);
    end
    for (int k = 0; k < NL; k++) begin
      chk("R9", $sformatf("pass[%0d]", k), pass_cnt[k*CW +: CW], m_pass[k]);
      chk("R9", $sformatf("drop[%0d]", k), drop_cnt[k*CW +: CW], m_drop[k]);
    end
  endtask

  // one clock: inputs already set at a negedge; result compared at next negedge
  task automatic step(string tag);
    bit found = 0, adm;
    int idx = 0;
    e_valid = fv;
    if (fv) begin
      for (int k = 0; k < NL; k++)
        if (!found && m_en[k] && m_dmac[k] == f_dmac && m_vid[k] == f_vid && m_pcp[k] == f_pcp) begin
          found = 1; idx = k;
        end
      adm = !found || ((m_act[idx] == 2'd1 || m_act[idx] == 2'd2) && gate[idx]);
      e_acc = adm; e_match = found; e_idx = found ? idx : 0;
      e_ports = (!found || !adm) ? '0 : (m_act[idx] == 2'd2 ? NP'(1) << CPU : m_ports[idx]);
      if (found && adm && m_pass[idx] < CMAX) m_pass[idx]++;
      if (found && !adm && m_drop[idx] < CMAX) m_drop[idx]++;
    end
    if (we) begin
      m_en[w_idx] = w_en; m_dmac[w_idx] = w_dmac; m_vid[w_idx] = w_vid;
      m_pcp[w_idx] = w_pcp; m_act[w_idx] = w_act; m_ports[w_idx] = w_ports;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    fv = 0; we = 0;
  endtask

  task automatic cfg(int idx, bit en, logic [47:0] dm, int vid, int pcp, int act, int ports);
    we = 1; w_idx = IW'(idx); w_en = en; w_dmac = dm; w_vid = 12'(vid);
    w_pcp = 3'(pcp); w_act = 2'(act); w_ports = NP'(ports);
    step("R12");
  endtask

  task automatic frame(string tag, logic [47:0] dm, int vid, int pcp);
    fv = 1; f_dmac = dm; f_vid = 12'(vid); f_pcp = 3'(pcp);
    step(tag);
  endtask

  localparam logic [47:0] MA = 48'h42be249b7620, MB = 48'h02aa00000011, MC = 48'h02cc00000022, MD = 48'h02dd00000033;

  initial begin
    for (int k = 0; k < NL; k++) begin
      m_en[k] = 0; m_dmac[k] = '0; m_vid[k] = '0; m_pcp[k] = '0;
      m_act[k] = '0; m_ports[k] = '0; m_pass[k] = 0; m_drop[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "dec_valid", d_valid, 0);
    chk("R11", "pass_cnt", pass_cnt, 0);
    chk("R11", "drop_cnt", drop_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    gate = '1;
    // R11 empty table: nothing matches (R8)
    frame("R11", MA, 10, 3);

    cfg(0, 1, MA, 10, 3, 1, 5'b00011);
    cfg(2, 1, MC, 20, 5, 2, 5'b00110);
    cfg(5, 1, MC, 20, 5, 1, 5'b01001);
    cfg(3, 1, MD, 7, 0, 0, 5'b11111);
    cfg(6, 1, MD, 8, 0, 3, 5'b11111);
    cfg(4, 1, MB, 1, 7, 1, 5'b00100);

    frame("R4", MA, 10, 3);
    frame("R1", MA, 11, 3);
    frame("R1", MA, 10, 2);
    frame("R1", MB, 10, 3);
    frame("R8", MB, 2, 7);
    gate[0] = 0;
    frame("R6", MA, 10, 3);
    gate[0] = 1;
    frame("R2", MC, 20, 5);   // idx 2 wins, trap
    frame("R5", MC, 20, 5);
    gate = '0;
    frame("R7", MD, 7, 0);
    gate = '1;
    frame("R7", MD, 7, 0);
    frame("R7", MD, 8, 0);
    step("R3");               // idle cycle
    step("R3");

    // R12: write and frame in the same cycle -> old entry used
    we = 1; w_idx = 3'd2; w_en = 0; w_dmac = MC; w_vid = 12'd20; w_pcp = 3'd5;
    w_act = 2'd2; w_ports = '0;
    fv = 1; f_dmac = MC; f_vid = 12'd20; f_pcp = 3'd5;
    step("R12");
    frame("R12", MC, 20, 5);  // entry 2 gone, entry 5 wins (R2)
    cfg(0, 1, MA, 10, 3, 2, 5'b00011);
    frame("R12", MA, 10, 3);  // now trap

    // R10 saturation, back-to-back frames
    for (int n = 0; n < CMAX + 3; n++) frame("R10", MB, 1, 7);
    gate[4] = 0;
    for (int n = 0; n < CMAX + 3; n++) frame("R10", MB, 1, 7);
    gate = '1;
    frame("R10", MB, 1, 7);
    step("R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule